// File: doc/BRIEF.md
# Autoinitializing DMA Channel Sequencer

This block is one single-channel DMA engine for an AT-class peripheral bus. Software loads a 16-bit start address and a 16-bit transfer count through an 8-bit register port, then unmasks the channel. While the device request is high and the channel is unmasked, the block raises a bus request and waits for the grant. Once it holds the grant, it runs one transfer cycle: it holds a cycle strobe, asserts the device acknowledge, and stretches the cycle by a programmed number of wait states and then by the bus ready input. After each cycle the address steps by one, up or down, and the count steps down by one.

The count is loaded as the number of transfers minus one. The terminal-count output marks the last cycle of a block, which is the cycle in which the count reads zero. At that point the channel does one of two things. In autoinitialize mode it copies its base registers back into the working registers and stays armed. Otherwise it masks itself until software clears the mask. Cycle timing follows a DMA tick. The tick is either every bus clock or every second bus clock, and every second clock is the reset choice. Narrow and wide transfers each have their own wait-state setting.

Top module: `dma_chan_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, bus_req, dack, cyc_stb and tc are 0 and addr_out is 0. The channel comes out of reset masked, so a high dreq produces no bus_req.
- R2: Register select 0 writes the address and select 1 writes the count. Both share one byte pointer, which reset clears. When the pointer is 0 a write sets the low byte, when it is 1 a write sets the high byte, and every such write toggles the pointer. A write to select 6 clears the pointer. Each byte write loads the base register and the working register together.
- R3: Select 3 bit 0 picks the tick rate: 1 gives a tick every clock, and 0 (the reset value) gives a tick every second clock. States advance only on ticks.
- R4: Select 3 bits 5:2 hold the wait count W for narrow transfers and select 4 bits 5:2 hold it for wide transfers. Mode bit 2 picks wide. With ready high, cyc_stb stays high for exactly W+1 ticks.
- R5: When the wait count is used up while bus_ready is low, cyc_stb stays high until a tick on which bus_ready is high.
- R6: bus_req is high from a granted request until the cycle ends. cyc_stb starts only after a tick that sees grant high. dack equals cyc_stb AND grant, so it falls on the clock after the last tick of the cycle.
- R7: Mode bit 1 = 0 adds one to the address after each transfer, and bit 1 = 1 subtracts one. Both wrap modulo 2^16.
- R8: A count of N-1 gives N transfers. tc is high exactly during the cycle in which the working count is 0.
- R9: When mode bit 0 = 1, the end of the tc cycle reloads the base address and base count and leaves the mask unchanged.
- R10: When mode bit 0 = 0, the end of the tc cycle sets the mask and leaves the count at 0xFFFF. After that no bus_req follows, even with dreq high.
- R11: Select 5 bit 0 writes the mask: 1 masks the channel and 0 unmasks it. A masked channel ignores dreq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| dreq | input | 1 | Device transfer request |
| grant | input | 1 | Bus grant from the arbiter |
| bus_ready | input | 1 | Cycle may complete |
| bus_req | output | 1 | Bus request to the arbiter |
| dack | output | 1 | Device acknowledge |
| cyc_stb | output | 1 | Transfer cycle in progress |
| tc | output | 1 | Terminal count, last cycle of the block |
| addr_out | output | 16 | Current transfer address |

## Verification
The hardest case to reach is the rollover at terminal count. At that point a count of zero, the reload and the mask update all land on the same edge, and the outcome depends on the mode. The stimulus programs very short blocks of one or two transfers so that terminal count comes quickly. It runs them back to back in autoinitialize mode with the fast tick and a wide wait setting, so several reloads happen in one run. A behavioural model follows every clock. The bench also records the strobe length, the tc flag and the address at the end of each cycle, and compares them directly with values worked out from the requirements.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int WAIT_W   = 4;
    localparam int WAIT_LSB = 2;
    localparam int SEL_W    = 3;
    localparam int CFG_W    = WAIT_LSB + WAIT_W;
    localparam int N_PAIR   = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_ADDR   = 3'd0,
        SEL_CNT    = 3'd1,
        SEL_MODE   = 3'd2,
        SEL_TIM8   = 3'd3,
        SEL_TIM16  = 3'd4,
        SEL_MASK   = 3'd5,
        SEL_PTRCLR = 3'd6,
        SEL_SPARE  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic wide;
        logic down;
        logic autoinit;
    } mode_t;

    typedef struct packed {
        logic [WAIT_W-1:0] wait8;
        logic [WAIT_W-1:0] wait16;
        logic              fast;
    } timing_t;

    function automatic logic [WAIT_W-1:0] pick_wait(input timing_t t, input mode_t m);
        return m.wide ? t.wait16 : t.wait8;
    endfunction

endpackage

// File: rtl/dmach_tick.sv
module dmach_tick (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    output logic tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign tick = fast | phase_q;
endmodule

// File: rtl/dmach_cfg.sv
module dmach_cfg
    import dmach_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [SEL_W-1:0]    sel,
    input  logic [CFG_W-1:0]    wdata,
    input  logic                set_mask,
    output mode_t               mode,
    output timing_t             timing,
    output logic                mask,
    output logic [N_PAIR-1:0]   wr_lo,
    output logic [N_PAIR-1:0]   wr_hi
);
    logic ptr_q;
    logic pair_wr;

    assign pair_wr = we && (sel == SEL_ADDR || sel == SEL_CNT);

    for (genvar i = 0; i < N_PAIR; i++) begin : g_strobe
        assign wr_lo[i] = we && (sel == SEL_W'(i)) && !ptr_q;
        assign wr_hi[i] = we && (sel == SEL_W'(i)) &&  ptr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= 1'b0;
            mode   <= '0;
            timing <= '0;
            mask   <= 1'b1;
        end else begin
            if (we && sel == SEL_PTRCLR) ptr_q <= 1'b0;
            else if (pair_wr)            ptr_q <= ~ptr_q;

            if (we && sel == SEL_MODE) begin
                mode.autoinit <= wdata[0];
                mode.down     <= wdata[1];
                mode.wide     <= wdata[2];
            end
            if (we && sel == SEL_TIM8) begin
                timing.fast  <= wdata[0];
                timing.wait8 <= wdata[WAIT_LSB +: WAIT_W];
            end
            if (we && sel == SEL_TIM16)
                timing.wait16 <= wdata[WAIT_LSB +: WAIT_W];

            if (set_mask)                    mask <= 1'b1;
            else if (we && sel == SEL_MASK)  mask <= wdata[0];
        end
    end

    // R2
    ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_wr && !(we && sel == SEL_PTRCLR)) |=> (ptr_q != $past(ptr_q)));
endmodule

// File: rtl/dmach_ctr.sv
module dmach_ctr
    import dmach_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_PAIR-1:0]           wr_lo,
    input  logic [N_PAIR-1:0]           wr_hi,
    input  logic [BYTE_W-1:0]           wdata,
    input  logic                        step,
    input  logic                        down,
    input  logic                        reload,
    output logic [N_PAIR-1:0][W-1:0]    cur
);
    localparam int HALF = W / 2;

    for (genvar i = 0; i < N_PAIR; i++) begin : g_pair
        logic [W-1:0] base_q;
        logic [W-1:0] cur_q;
        logic [W-1:0] stepped;

        if (i == 0) begin : g_addr
            assign stepped = down ? cur_q - W'(1) : cur_q + W'(1);
        end else begin : g_count
            assign stepped = cur_q - W'(1);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
                cur_q  <= '0;
            end else begin
                if (wr_lo[i]) base_q[HALF-1:0] <= wdata[HALF-1:0];
                if (wr_hi[i]) base_q[W-1:HALF] <= wdata[HALF-1:0];

                if (reload)         cur_q <= base_q;
                else if (step)      cur_q <= stepped;
                else begin
                    if (wr_lo[i]) cur_q[HALF-1:0] <= wdata[HALF-1:0];
                    if (wr_hi[i]) cur_q[W-1:HALF] <= wdata[HALF-1:0];
                end
            end
        end

        assign cur[i] = cur_q;

        // R9
        reload_copy_chk: assert property (@(posedge clk) disable iff (rst)
            (reload && wr_lo[i] == 1'b0 && wr_hi[i] == 1'b0) |=> (cur_q == base_q));
    end
endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
    import dmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              dreq,
    input  logic              mask,
    input  logic              grant,
    input  logic              bus_ready,
    input  logic [WAIT_W-1:0] wait_sel,
    input  logic              cnt_zero,
    output logic              bus_req,
    output logic              dack,
    output logic              cyc_stb,
    output logic              tc,
    output logic              done
);
    seq_state_e        state_q;
    logic [WAIT_W-1:0] wcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: if (dreq && !mask) state_q <= ST_REQ;
                ST_REQ: if (grant) begin
                    state_q <= ST_XFER;
                    wcnt_q  <= wait_sel;
                end
                ST_XFER: begin
                    if (wcnt_q != '0)   wcnt_q  <= wcnt_q - 1'b1;
                    else if (bus_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign bus_req = (state_q != ST_IDLE);
    assign cyc_stb = (state_q == ST_XFER);
    assign dack    = cyc_stb && grant;
    assign tc      = cyc_stb && cnt_zero;
    assign done    = cyc_stb && tick && (wcnt_q == '0) && bus_ready;

    // R4
    wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && tick && wcnt_q != '0) |=> cyc_stb);
    // R5
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && !bus_ready) |=> cyc_stb);
    // R6
    dack_grant_chk: assert property (@(posedge clk) disable iff (rst)
        dack |-> (grant && bus_req));
    // R6
    start_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cyc_stb) |-> $past(grant && tick));
    // R3
    idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && state_q == ST_IDLE) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dmach_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    input  logic        dreq,
    input  logic        grant,
    input  logic        bus_ready,
    output logic        bus_req,
    output logic        dack,
    output logic        cyc_stb,
    output logic        tc,
    output logic [15:0] addr_out
);
    mode_t                          mode;
    timing_t                        timing;
    logic                           mask;
    logic [N_PAIR-1:0]              wr_lo;
    logic [N_PAIR-1:0]              wr_hi;
    logic                           tick;
    logic                           done;
    logic                           cnt_zero;
    logic                           reload;
    logic                           set_mask;
    logic [N_PAIR-1:0][WORD_W-1:0]  cur;

    assign cnt_zero = (cur[1] == '0);
    assign reload   = done && cnt_zero &&  mode.autoinit;
    assign set_mask = done && cnt_zero && !mode.autoinit;

    dmach_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .sel      (reg_sel),
        .wdata    (reg_wdata[CFG_W-1:0]),
        .set_mask (set_mask),
        .mode     (mode),
        .timing   (timing),
        .mask     (mask),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi)
    );

    dmach_tick u_tick (
        .clk  (clk),
        .rst  (rst),
        .fast (timing.fast),
        .tick (tick)
    );

    dmach_ctr #(.W(WORD_W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wdata  (reg_wdata),
        .step   (done),
        .down   (mode.down),
        .reload (reload),
        .cur    (cur)
    );

    dmach_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .dreq      (dreq),
        .mask      (mask),
        .grant     (grant),
        .bus_ready (bus_ready),
        .wait_sel  (pick_wait(timing, mode)),
        .cnt_zero  (cnt_zero),
        .bus_req   (bus_req),
        .dack      (dack),
        .cyc_stb   (cyc_stb),
        .tc        (tc),
        .done      (done)
    );

    assign addr_out = cur[0];

    // R10
    mask_after_tc_chk: assert property (@(posedge clk) disable iff (rst)
        (done && tc && !mode.autoinit) |=> (mask && cur[1] == '1));
    // R9
    rearm_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (done && tc && mode.autoinit && !(reg_we && reg_sel == SEL_MASK)) |=> $stable(mask));
    // R11
    masked_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mask && !bus_req) |=> !bus_req);
    // R8
    tc_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tc |-> cyc_stb);
endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        dreq = 1'b0;
    logic        grant = 1'b1;
    logic        bus_ready = 1'b1;
    logic        bus_req, dack, cyc_stb, tc;
    logic [15:0] addr_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    dma_chan_seq uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .dreq(dreq), .grant(grant),
        .bus_ready(bus_ready), .bus_req(bus_req), .dack(dack),
        .cyc_stb(cyc_stb), .tc(tc), .addr_out(addr_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_st;      // 0 idle, 1 requesting, 2 in cycle
    int          m_w;
    bit          m_phase, m_fast, m_auto, m_down, m_wide, m_mask, m_ptr;
    int          m_wait8, m_wait16;
    logic [15:0] m_addr, m_cnt, m_baddr, m_bcnt;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_w = 0; m_phase = 0; m_fast = 0; m_auto = 0; m_down = 0;
            m_wide = 0; m_mask = 1; m_ptr = 0; m_wait8 = 0; m_wait16 = 0;
            m_addr = 0; m_cnt = 0; m_baddr = 0; m_bcnt = 0;
        end else begin
            bit tk;
            int nst, nw;
            tk  = m_fast || m_phase;
            nst = m_st; nw = m_w;
            if (m_st == 2 && tk && m_w == 0 && bus_ready) begin
                if (m_cnt == 0 && m_auto) begin
                    m_addr = m_baddr; m_cnt = m_bcnt;
                end else begin
                    if (m_cnt == 0) m_mask = 1;
                    m_addr = m_down ? m_addr - 16'd1 : m_addr + 16'd1;
                    m_cnt  = m_cnt - 16'd1;
                end
            end
            if (tk) begin
                if (m_st == 0 && dreq && !m_mask) nst = 1;
                else if (m_st == 1 && grant) begin nst = 2; nw = m_wide ? m_wait16 : m_wait8; end
                else if (m_st == 2) begin
                    if (m_w != 0) nw = m_w - 1;
                    else if (bus_ready) nst = 0;
                end
            end
            m_st = nst; m_w = nw;
            if (reg_we) begin
                case (reg_sel)
                    3'd0, 3'd1: begin
                        if (reg_sel == 3'd0) begin
                            if (m_ptr) begin m_baddr[15:8] = reg_wdata; m_addr[15:8] = reg_wdata; end
                            else       begin m_baddr[7:0]  = reg_wdata; m_addr[7:0]  = reg_wdata; end
                        end else begin
                            if (m_ptr) begin m_bcnt[15:8] = reg_wdata; m_cnt[15:8] = reg_wdata; end
                            else       begin m_bcnt[7:0]  = reg_wdata; m_cnt[7:0]  = reg_wdata; end
                        end
                        m_ptr = !m_ptr;
                    end
                    3'd2: begin m_auto = reg_wdata[0]; m_down = reg_wdata[1]; m_wide = reg_wdata[2]; end
                    3'd3: begin m_fast = reg_wdata[0]; m_wait8 = int'(reg_wdata[5:2]); end
                    3'd4: m_wait16 = int'(reg_wdata[5:2]);
                    3'd5: m_mask = reg_wdata[0];
                    3'd6: m_ptr = 0;
                    default: ;
                endcase
            end
            m_phase = !m_phase;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !finished) begin
            check(bus_req == (m_st != 0), "R6 bus_req vs model", bus_req, m_st != 0);
            check(cyc_stb == (m_st == 2), "R4 cyc_stb vs model", cyc_stb, m_st == 2);
            check(dack == (m_st == 2 && grant), "R6 dack vs model", dack, m_st == 2 && grant);
            check(tc == (m_st == 2 && m_cnt == 0), "R8 tc vs model", tc, m_st == 2 && m_cnt == 0);
            check(addr_out == m_addr, "R7 addr_out vs model", addr_out, m_addr);
        end
    end

    // cycle monitor: strobe length, tc seen, address after the cycle
    int q_len[$];
    bit q_tc[$];
    int q_addr[$];
    int run_len = 0;
    bit run_tc = 0;
    always @(negedge clk) begin
        #2;
        if (cyc_stb) begin
            run_len++;
            if (tc) run_tc = 1;
        end else if (run_len > 0) begin
            q_len.push_back(run_len);
            q_tc.push_back(run_tc);
            q_addr.push_back(int'(addr_out));
            run_len = 0; run_tc = 0;
        end
    end

    task automatic wr(input int sel, input int data);
        reg_sel = 3'(sel); reg_wdata = 8'(data); reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && (bus_req || cyc_stb); i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 outputs while reset is high
        check(!bus_req && !dack && !cyc_stb && !tc, "R1 outputs in reset", {bus_req, dack, cyc_stb, tc}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(addr_out == 16'h0, "R1 address after reset", addr_out, 0);
        check(!bus_req && !dack && !cyc_stb && !tc, "R1 outputs after reset", {bus_req, dack, cyc_stb, tc}, 0);
        dreq = 1'b1;
        repeat (8) @(negedge clk);
        check(!bus_req, "R1 masked after reset ignores dreq", bus_req, 0);
        dreq = 1'b0;

        // R2 byte pointer
        wr(0, 8'h34);
        check(addr_out == 16'h0034, "R2 low byte", addr_out, 16'h0034);
        wr(0, 8'h12);
        check(addr_out == 16'h1234, "R2 high byte", addr_out, 16'h1234);
        wr(0, 8'h78);
        check(addr_out == 16'h1278, "R2 pointer wraps to low", addr_out, 16'h1278);
        wr(6, 0);
        wr(0, 8'h9A);
        check(addr_out == 16'h129A, "R2 pointer clear", addr_out, 16'h129A);
        wr(0, 8'h56);
        check(addr_out == 16'h569A, "R2 second high byte", addr_out, 16'h569A);

        // Block A: 3 transfers, increment, no autoinit, slow tick, W=1
        wr(1, 2); wr(1, 0);
        wr(2, 0);
        wr(3, 8'h04);
        wr(5, 0);
        q_len.delete(); q_tc.delete(); q_addr.delete();
        dreq = 1'b1;
        repeat (80) @(negedge clk);
        check(q_len.size() == 3, "R8 three transfers from count 2", q_len.size(), 3);
        foreach (q_len[i]) begin
            check(q_len[i] == 4, "R3 R4 slow strobe length (W+1)*2", q_len[i], 4);
            check(q_tc[i] == (i == 2), "R8 tc only on final transfer", q_tc[i], i == 2);
            check(q_addr[i] == 16'h569B + i, "R7 address increments", q_addr[i], 16'h569B + i);
        end
        check(!bus_req, "R10 masked after tc without autoinit", bus_req, 0);
        dreq = 1'b0;

        // R11 mask write
        wr(1, 5); wr(1, 0);
        wr(5, 1);
        dreq = 1'b1;
        repeat (10) @(negedge clk);
        check(!bus_req, "R11 mask set blocks dreq", bus_req, 0);
        dreq = 1'b0;
        wr(5, 0);
        dreq = 1'b1;
        repeat (4) @(negedge clk);
        check(bus_req, "R11 mask clear allows request", bus_req, 1);
        dreq = 1'b0;
        wait_idle();

        // R6 grant withheld
        grant = 1'b0;
        dreq = 1'b1;
        repeat (8) @(negedge clk);
        check(bus_req && !cyc_stb && !dack, "R6 waits for grant", {bus_req, cyc_stb, dack}, 3'b100);
        grant = 1'b1;
        repeat (3) @(negedge clk);
        check(cyc_stb && dack, "R6 cycle after grant", {cyc_stb, dack}, 2'b11);
        dreq = 1'b0;
        wait_idle();

        // Block B: autoinit, decrement, wide W=2, fast tick, 2 transfers per block
        wr(6, 0);
        wr(0, 8'h10); wr(0, 8'h00);
        wr(1, 1); wr(1, 0);
        wr(2, 7);
        wr(4, 8'h08);
        wr(3, 8'h01);
        q_len.delete(); q_tc.delete(); q_addr.delete();
        dreq = 1'b1;
        for (int i = 0; i < 200 && q_len.size() < 5; i++) @(negedge clk);
        dreq = 1'b0;
        check(q_len.size() >= 5, "R9 channel keeps rearming", q_len.size(), 5);
        for (int i = 0; i < 5 && i < q_len.size(); i++) begin
            int ea;
            ea = (i % 2 == 0) ? 16'h000F : 16'h0010;
            check(q_len[i] == 3, "R3 R4 fast wide strobe length W+1", q_len[i], 3);
            check(q_tc[i] == (i % 2 == 1), "R8 tc every second transfer", q_tc[i], i % 2 == 1);
            check(q_addr[i] == ea, "R7 R9 decrement and reload", q_addr[i], ea);
        end
        wait_idle();

        // R5 ready held low, single transfer, no autoinit
        wr(2, 0);
        wr(3, 8'h01);
        wr(1, 0); wr(1, 0);
        bus_ready = 1'b0;
        dreq = 1'b1;
        for (int i = 0; i < 50 && !cyc_stb; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        check(cyc_stb && tc, "R5 cycle held while not ready", {cyc_stb, tc}, 2'b11);
        bus_ready = 1'b1;
        repeat (2) @(negedge clk);
        check(!cyc_stb, "R5 cycle ends once ready", cyc_stb, 0);
        repeat (6) @(negedge clk);
        check(!bus_req, "R10 single-transfer block masks channel", bus_req, 0);
        dreq = 1'b0;
        repeat (3) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule